// File: doc/BRIEF.md
# PCIe Interrupt Status Concentrator

This block gathers the interrupt events that a PCIe root port receives and presents them to software as a small tree of status registers with one level-sensitive interrupt line. Inbound legacy INTx assert and deassert messages, PME messages, power-state changes and flush events set bits in two core status registers. Inbound MSI writes set one of 32 vector bits and store the written payload, so that software can read back which interrupt was raised.

Each status register has its own mask, where a 1 disables the matching source. The unmasked MSI vectors feed an MSI-pending bit in the first core status register. Any unmasked core status bit sets a core-interrupt bit in a top-level summary register. The output line stays high while any unmasked top-level bit is pending. Every status bit is cleared by writing 1 to it. A hardware set that lands in the same cycle as a software clear wins.

Top module: `isr_concentrator`

## Requirements
- R1: After reset all status registers and the payload read 0, the masks read all implemented bits set (0x07FFFFFF, 0x00000FF0, 0xFFFFFFFF, 0x00FFF0FB) and irq_o is low.
- R2: Each event sets a bit in core status A. An INTx n assert sets bit 16+n, an INTx n deassert sets bit 20+n, and PME sets bit 7. An INTx n assert also sets bit 8+n of core status B. Power change sets bit 4 and flush sets bit 5 of core status B.
- R3: An MSI write sets bit payload[4:0] of the MSI status register and stores the full 32-bit payload, which reads back at address 6.
- R4: An MSI write sets bit 24 of core status A only when its vector bit in the MSI mask is 0.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and unimplemented bits always read 0.
- R6: When a hardware set and a software write-1 clear hit the same bit in the same cycle, the bit stays set.
- R7: Top-level bit 16 is set in the cycle after any bit of core status A or B is set with its mask bit 0. Masked bits never set it.
- R8: irq_o is high exactly while (top status AND NOT top mask AND 0x00FFF0FB) is nonzero.
- R9: Word addresses: 0 core status A, 1 mask A, 2 core status B, 3 mask B, 4 MSI status, 5 MSI mask, 6 payload (read-only), 7 top status, 8 top mask. Other addresses read 0. Mask writes keep only the implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| intx_assert | input | 4 | One-cycle INTA..INTD assert events |
| intx_deassert | input | 4 | One-cycle INTA..INTD deassert events |
| pme_evt | input | 1 | One-cycle PME message event |
| pwr_evt | input | 1 | One-cycle power-state change event |
| flush_evt | input | 1 | One-cycle flush event |
| msi_valid | input | 1 | One-cycle inbound MSI write |
| msi_data | input | 32 | MSI payload |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions take for granted that event inputs and msi_valid last one cycle and that a write strobe lasts one cycle with a stable address. Under those conditions each set or clear shows in the following cycle. The stimulus drives every event and write for exactly one clock, from the falling edge, and reads only on falling edges. Same-cycle set and clear collisions are created on purpose and only through the ports, so the set-wins rule is tested under the same conditions that the assertions assume.

// File: rtl/isr_agg_pkg.sv
package isr_agg_pkg;
  localparam int REG_W = 32;

  localparam logic [REG_W-1:0] ST_A_IMPL = 32'h07FF_FFFF;
  localparam logic [REG_W-1:0] ST_B_IMPL = 32'h0000_0FF0;
  localparam logic [REG_W-1:0] TOP_IMPL  = 32'h00FF_F0FB;

  localparam int A_PME_BIT   = 7;
  localparam int A_INTX_AS   = 16;
  localparam int A_INTX_DE   = 20;
  localparam int A_MSI_BIT   = 24;
  localparam int B_PWR_BIT   = 4;
  localparam int B_FLUSH_BIT = 5;
  localparam int B_INTX_AS   = 8;
  localparam int TOP_CORE    = 16;

  typedef enum logic [3:0] {
    AD_ST_A   = 4'd0,
    AD_MK_A   = 4'd1,
    AD_ST_B   = 4'd2,
    AD_MK_B   = 4'd3,
    AD_MSI_ST = 4'd4,
    AD_MSI_MK = 4'd5,
    AD_PAYLD  = 4'd6,
    AD_TOP_ST = 4'd7,
    AD_TOP_MK = 4'd8
  } reg_addr_e;

  // next value of a write-1-to-clear status word; a set overrides a clear
  function automatic logic [REG_W-1:0] w1c_next(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] clr,
                                                input logic [REG_W-1:0] set,
                                                input logic [REG_W-1:0] impl);
    return ((cur & ~clr) | set) & impl;
  endfunction

  // status bits that are allowed to reach the next level
  function automatic logic [REG_W-1:0] unmasked(input logic [REG_W-1:0] st,
                                                input logic [REG_W-1:0] mk,
                                                input logic [REG_W-1:0] impl);
    return st & ~mk & impl;
  endfunction
endpackage

// File: rtl/isr_w1c_reg.sv
module isr_w1c_reg
  import isr_agg_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] set_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] set_vec;

  assign clr_vec = wr_i ? wdata_i : '0;
  assign set_vec = set_i & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= w1c_next(q_o, clr_vec, set_vec, IMPL);
  end

  // R5: a write-1 clear with no simultaneous set empties the bit
  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((q_o & $past(wdata_i & ~set_vec)) == '0));

  // R6: a hardware set always lands, whatever the bus does
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((q_o & $past(set_vec)) == $past(set_vec)));

  // R5: unimplemented bits stay clear
  a_r5_impl_only: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o & ~IMPL) == '0);
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg
  import isr_agg_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= IMPL;
    else if (wr_i) q_o <= wdata_i & IMPL;
  end
endmodule

// File: rtl/isr_concentrator.sv
module isr_concentrator
  import isr_agg_pkg::*;
#(
  parameter int MSI_VEC = 32,
  parameter int INTX_N  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [INTX_N-1:0] intx_assert,
  input  logic [INTX_N-1:0] intx_deassert,
  input  logic             pme_evt,
  input  logic             pwr_evt,
  input  logic             flush_evt,
  input  logic             msi_valid,
  input  logic [REG_W-1:0] msi_data,
  output logic             irq_o
);
  localparam int IDX_W = $clog2(MSI_VEC);
  localparam logic [REG_W-1:0] MSI_IMPL =
    (MSI_VEC >= REG_W) ? '1 : ((REG_W'(1) << MSI_VEC) - REG_W'(1));

  logic [REG_W-1:0] st_a, st_b, st_msi, st_top;
  logic [REG_W-1:0] mk_a, mk_b, mk_msi, mk_top;
  logic [REG_W-1:0] set_a, set_b, set_msi, set_top;
  logic [REG_W-1:0] payload_q;
  logic [IDX_W-1:0] msi_idx;
  logic             msi_hit;   // inbound MSI on an unmasked vector
  logic             core_sum;  // any unmasked core status bit
  logic [REG_W-1:0] top_eff;

  function automatic logic wsel(input logic wr, input logic [3:0] a, input reg_addr_e t);
    return wr && (a == t);
  endfunction

  // event routing
  assign msi_idx = msi_data[IDX_W-1:0];
  assign msi_hit = msi_valid && !mk_msi[msi_idx];

  always_comb begin
    set_a = '0;
    set_b = '0;
    set_a[A_PME_BIT]   = pme_evt;
    set_a[A_MSI_BIT]   = msi_hit;
    set_b[B_PWR_BIT]   = pwr_evt;
    set_b[B_FLUSH_BIT] = flush_evt;
    for (int n = 0; n < INTX_N; n++) begin
      set_a[A_INTX_AS + n] = intx_assert[n];
      set_a[A_INTX_DE + n] = intx_deassert[n];
      set_b[B_INTX_AS + n] = intx_assert[n];
    end
  end

  assign set_msi = msi_valid ? (REG_W'(1) << msi_idx) : '0;

  assign core_sum = |unmasked(st_a, mk_a, ST_A_IMPL) | |unmasked(st_b, mk_b, ST_B_IMPL);
  assign set_top  = core_sum ? (REG_W'(1) << TOP_CORE) : '0;
  assign top_eff  = unmasked(st_top, mk_top, TOP_IMPL);
  assign irq_o    = |top_eff;

  // status registers
  isr_w1c_reg #(.IMPL(ST_A_IMPL)) u_st_a (
    .clk(clk), .rst_n(rst_n), .wr_i(wsel(bus_wr, bus_addr, AD_ST_A)),
    .wdata_i(bus_wdata), .set_i(set_a), .q_o(st_a));
  isr_w1c_reg #(.IMPL(ST_B_IMPL)) u_st_b (
    .clk(clk), .rst_n(rst_n), .wr_i(wsel(bus_wr, bus_addr, AD_ST_B)),
    .wdata_i(bus_wdata), .set_i(set_b), .q_o(st_b));
  isr_w1c_reg #(.IMPL(MSI_IMPL)) u_st_msi (
    .clk(clk), .rst_n(rst_n), .wr_i(wsel(bus_wr, bus_addr, AD_MSI_ST)),
    .wdata_i(bus_wdata), .set_i(set_msi), .q_o(st_msi));
  isr_w1c_reg #(.IMPL(TOP_IMPL)) u_st_top (
    .clk(clk), .rst_n(rst_n), .wr_i(wsel(bus_wr, bus_addr, AD_TOP_ST)),
    .wdata_i(bus_wdata), .set_i(set_top), .q_o(st_top));

  // mask registers
  isr_mask_reg #(.IMPL(ST_A_IMPL)) u_mk_a (
    .clk(clk), .rst_n(rst_n), .wr_i(wsel(bus_wr, bus_addr, AD_MK_A)),
    .wdata_i(bus_wdata), .q_o(mk_a));
  isr_mask_reg #(.IMPL(ST_B_IMPL)) u_mk_b (
    .clk(clk), .rst_n(rst_n), .wr_i(wsel(bus_wr, bus_addr, AD_MK_B)),
    .wdata_i(bus_wdata), .q_o(mk_b));
  isr_mask_reg #(.IMPL(MSI_IMPL)) u_mk_msi (
    .clk(clk), .rst_n(rst_n), .wr_i(wsel(bus_wr, bus_addr, AD_MSI_MK)),
    .wdata_i(bus_wdata), .q_o(mk_msi));
  isr_mask_reg #(.IMPL(TOP_IMPL)) u_mk_top (
    .clk(clk), .rst_n(rst_n), .wr_i(wsel(bus_wr, bus_addr, AD_TOP_MK)),
    .wdata_i(bus_wdata), .q_o(mk_top));

  // payload capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         payload_q <= '0;
    else if (msi_valid) payload_q <= msi_data;
  end

  // read mux
  always_comb begin
    unique case (bus_addr)
      AD_ST_A:   bus_rdata = st_a;
      AD_MK_A:   bus_rdata = mk_a;
      AD_ST_B:   bus_rdata = st_b;
      AD_MK_B:   bus_rdata = mk_b;
      AD_MSI_ST: bus_rdata = st_msi;
      AD_MSI_MK: bus_rdata = mk_msi;
      AD_PAYLD:  bus_rdata = payload_q;
      AD_TOP_ST: bus_rdata = st_top;
      AD_TOP_MK: bus_rdata = mk_top;
      default:   bus_rdata = '0;
    endcase
  end

  // R3: payload of an MSI write is held afterwards
  a_r3_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> (payload_q == $past(msi_data)));

  // R3: the indexed vector is pending after an MSI write
  a_r3_vector_set: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> st_msi[$past(msi_idx)]);

  // R4: an unmasked MSI raises the pending bit of core status A
  a_r4_msi_pending: assert property (@(posedge clk) disable iff (!rst_n)
    msi_hit |=> st_a[A_MSI_BIT]);

  // R7: an unmasked core bit reaches the top-level core bit
  a_r7_summary: assert property (@(posedge clk) disable iff (!rst_n)
    core_sum |=> st_top[TOP_CORE]);

  // R8: the output line never rises without a pending top-level bit
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|st_top));
endmodule

// File: tb/sim_isr_concentrator.sv
module sim_isr_concentrator;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] E_IMPL_A = 32'h07FF_FFFF;
  localparam logic [31:0] E_IMPL_B = 32'h0000_0FF0;
  localparam logic [31:0] E_IMPL_T = 32'h00FF_F0FB;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  intx_assert = 0;
  logic [3:0]  intx_deassert = 0;
  logic        pme_evt = 0, pwr_evt = 0, flush_evt = 0;
  logic        msi_valid = 0;
  logic [31:0] msi_data = 0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_concentrator u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .intx_assert(intx_assert),
    .intx_deassert(intx_deassert), .pme_evt(pme_evt), .pwr_evt(pwr_evt),
    .flush_evt(flush_evt), .msi_valid(msi_valid), .msi_data(msi_data),
    .irq_o(irq_o));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic msi_send(input logic [31:0] p);
    @(negedge clk);
    msi_valid = 1; msi_data = p;
    @(negedge clk);
    msi_valid = 0;
  endtask

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 st_a", 0, 0);
    rd_chk("R1 mk_a", 1, E_IMPL_A);
    rd_chk("R1 st_b", 2, 0);
    rd_chk("R1 mk_b", 3, E_IMPL_B);
    rd_chk("R1 msi_st", 4, 0);
    rd_chk("R1 msi_mk", 5, 32'hFFFF_FFFF);
    rd_chk("R1 payload", 6, 0);
    rd_chk("R1 top_st", 7, 0);
    rd_chk("R1 top_mk", 8, E_IMPL_T);
    check("R1 irq", {31'd0, irq_o}, 0);

    // R9 map and mask width
    rd_chk("R9 unmapped", 4'd9, 0);
    rd_chk("R9 unmapped", 4'd15, 0);
    wr(3, 32'hFFFF_FFFF);
    rd_chk("R9 mk_b impl", 3, E_IMPL_B);
    wr(1, 32'h0);
    rd_chk("R9 mk_a zero", 1, 0);
    wr(1, 32'hFFFF_FFFF);
    rd_chk("R9 mk_a impl", 1, E_IMPL_A);
    wr(6, 32'h1234_5678);
    rd_chk("R9 payload ro", 6, 0);

    // R2 INTx sweep with everything masked; R7 masked bits do not summarize
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); intx_assert[n] = 1;
      @(negedge clk); intx_assert[n] = 0;
      rd_chk("R2 assert st_a", 0, 32'd1 << (16 + n));
      rd_chk("R2 assert st_b", 2, 32'd1 << (8 + n));
      @(negedge clk);
      rd_chk("R7 masked top", 7, 0);
      wr(0, 32'hFFFF_FFFF);
      wr(2, 32'hFFFF_FFFF);
      rd_chk("R5 cleared a", 0, 0);
      rd_chk("R5 cleared b", 2, 0);
      @(negedge clk); intx_deassert[n] = 1;
      @(negedge clk); intx_deassert[n] = 0;
      rd_chk("R2 deassert st_a", 0, 32'd1 << (20 + n));
      rd_chk("R2 deassert st_b", 2, 0);
      wr(0, 32'd1 << (20 + n));
      rd_chk("R5 cleared deassert", 0, 0);
    end

    // R2 PME, power change, flush
    @(negedge clk); pwr_evt = 1;
    @(negedge clk); pwr_evt = 0; flush_evt = 1;
    @(negedge clk); flush_evt = 0; pme_evt = 1;
    @(negedge clk); pme_evt = 0;
    rd_chk("R2 pwr+flush", 2, 32'h30);
    rd_chk("R2 pme", 0, 32'h80);

    // R5 writing 0 / unrelated ones keep the bit
    wr(0, 32'h0);
    rd_chk("R5 write 0 keeps", 0, 32'h80);
    wr(2, 32'h10);
    rd_chk("R5 partial clear", 2, 32'h20);
    wr(2, 32'h20);
    rd_chk("R5 clear b", 2, 0);

    // R7 summary: unmask PME in mask A
    wr(1, E_IMPL_A & ~32'h80);
    @(negedge clk);
    rd_chk("R7 top core set", 7, 32'h0001_0000);
    check("R8 irq masked by top", {31'd0, irq_o}, 0);
    wr(8, E_IMPL_T & ~32'h0001_0000);
    check("R8 irq high", {31'd0, irq_o}, 1);
    wr(7, 32'h0001_0000);
    rd_chk("R6 top reset while pending", 7, 32'h0001_0000);
    wr(0, 32'h80);
    rd_chk("R7 top holds one more cycle", 7, 32'h0001_0000);
    wr(7, 32'h0001_0000);
    rd_chk("R7 top cleared", 7, 0);
    check("R8 irq low", {31'd0, irq_o}, 0);

    // R7 via core status B
    wr(3, E_IMPL_B & ~32'h10);
    @(negedge clk); pwr_evt = 1;
    @(negedge clk); pwr_evt = 0;
    @(negedge clk);
    rd_chk("R7 top from b", 7, 32'h0001_0000);
    check("R8 irq from b", {31'd0, irq_o}, 1);
    wr(2, 32'h10);
    wr(7, 32'h0001_0000);
    check("R8 irq low again", {31'd0, irq_o}, 0);
    wr(3, E_IMPL_B);
    wr(8, E_IMPL_T);

    // R3/R4 MSI sweep: odd vectors masked
    wr(5, 32'hAAAA_AAAA);
    for (int i = 0; i < 32; i++) begin
      p = {8'(i) ^ 8'hC3, 16'(i * 1234), 3'(i), 5'(i)};
      msi_send(p);
      rd_chk("R3 msi vector", 4, 32'd1 << i);
      rd_chk("R3 payload", 6, p);
      rd_chk("R4 msi pending", 0, (i % 2 == 0) ? 32'h0100_0000 : 32'h0);
      wr(4, 32'd1 << i);
      wr(0, 32'h0100_0000);
      rd_chk("R5 msi cleared", 4, 0);
    end

    // R6 same-cycle set and clear on core status A
    @(negedge clk);
    bus_wr = 1; bus_addr = 0; bus_wdata = 32'h0001_0000; intx_assert[0] = 1;
    @(negedge clk);
    bus_wr = 0; intx_assert[0] = 0;
    rd_chk("R6 set wins st_a", 0, 32'h0001_0000);
    wr(0, 32'h0001_0000);
    wr(2, 32'hFFFF_FFFF);
    rd_chk("R6 then clears", 0, 0);

    // R6 same-cycle set and clear on MSI status
    msi_send(32'h0000_0003);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4; bus_wdata = 32'h8; msi_valid = 1; msi_data = 32'h0000_0003;
    @(negedge clk);
    bus_wr = 0; msi_valid = 0;
    rd_chk("R6 msi set wins", 4, 32'h8);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule